// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

The block holds a 2048-byte bank of shared counters, packed as 64-bit words, and performs one atomic read-modify-write per request. A load request names a byte address, an access size of 1, 2, 4 or 8 bytes and a signed 22-bit increment. It returns the field's value from before the update and writes back the sum. A store request supplies a data word and either adds it to the field or overwrites the field. Every request, load or store, gets exactly one response.

A load may instead ask to be held until an external tag-switch-done signal is seen. While held, the block accepts no other request. If the signal does not arrive within a parameterised number of cycles, the request is abandoned with an error response and the counter is not touched. Requests are served strictly one at a time, so a request that directly follows another sees that request's result.

Top module: `fetch_add_bank`

## Requirements
- R1: A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. The response (`rsp_valid` high for one cycle) comes from the next edge, with `rsp_data` holding the field's prior value zero-extended. A load leaves the field equal to prior value plus increment.
- R2: `req_cmd` holds the increment in [35:14], the flag in [13], the size code in [12:11] (0=1, 1=2, 2=4, 3=8 bytes) and the byte address in [10:0].
- R3: The 22-bit increment is sign-extended and then cut to the access width. An 8- or 16-bit access uses its low 8 or 16 bits, so -1 added to a zero 32-bit or 64-bit field gives all ones.
- R4: Sums wrap modulo the access width, and bytes of the word outside the addressed field never change.
- R5: Bytes in a word are big-endian. Byte offset 0 (address bits [2:0]) is word bits [63:56], and a field starts at its lowest-addressed, most significant byte.
- R6: For a store (`req_store`=1), flag 0 adds the low access-width bits of `req_wdata` to the field and flag 1 overwrites the field with them. The response carries the prior value.
- R7: An address that is not a multiple of the access size gives `rsp_err`=1 and `rsp_data`=64'h8000_0000_0000_0000, with no update. This also applies to held loads, which are then not held.
- R8: A load with flag 1 is held, with `req_ready` low. The update is made at the first edge where `tag_done` is sampled high. The response then has bit 63 clear and bits [62:0] equal to the prior value's low 63 bits.
- R9: If `tag_done` is not seen within TIMEOUT_CYCLES edges after acceptance, the response at the last of those edges is an error (as in R7) with no update. `tag_done` sampled high at that last edge still wins.
- R10: Back-to-back requests to the same field are applied in order with no lost update.
- R11: After reset every counter reads zero, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_store | input | 1 | 1 = store request, 0 = load request |
| req_cmd | input | 36 | Increment, flag, size code and byte address |
| req_wdata | input | 64 | Store data (low access-width bits used) |
| tag_done | input | 1 | Tag switch completed, releases a held load |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_err | output | 1 | Response is an error (misaligned or timed out) |
| rsp_data | output | 64 | Prior field value or error pattern |

## Verification
Two pairs of events can land on the same edge. The first pair is a new request and the write-back of the request just before it. The bench provokes this by issuing loads and stores to one field on consecutive edges and checking that each response equals the running sum from an independent byte-level model. The second pair is the timeout expiry and the arrival of `tag_done`. The bench raises `tag_done` exactly in the final window cycle and checks for a successful, updated response rather than an error. It also measures the response edge for every hold delay from 1 up to the timeout.

// File: rtl/fetch_add_pkg.sv
package fetch_add_pkg;

  localparam int CMD_W  = 36;
  localparam int INCR_W = 22;
  localparam int BADR_W = 11;
  localparam int WORD_W = 64;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } size_e;

  typedef struct packed {
    logic [INCR_W-1:0] incr;
    logic              flag;
    size_e             size;
    logic [BADR_W-1:0] addr;
  } cmd_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } state_e;

  localparam logic [WORD_W-1:0] ERR_PATTERN = {1'b1, {(WORD_W-1){1'b0}}};

endpackage

// File: rtl/fetch_add_decode.sv
module fetch_add_decode
  import fetch_add_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  cmd_t              cmd,
  input  logic              is_store,
  input  logic [WORD_W-1:0] wdata,
  output logic [IDX_W-1:0]  word_idx,
  output logic [5:0]        lsb,
  output logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] opnd,
  output logic              misalign,
  output logic              noadd,
  output logic              tagwait
);

  logic [2:0]        off;
  logic [3:0]        nbytes;
  logic [3:0]        nb_m1;
  logic [4:0]        slot;
  logic [WORD_W-1:0] incr_ext;

  always_comb begin
    off      = cmd.addr[2:0];
    word_idx = cmd.addr[IDX_W+2:3];
    nbytes   = 4'd1 << cmd.size;
    nb_m1    = nbytes - 4'd1;
    misalign = |(off & nb_m1[2:0]);
    // big-endian: offset 0 is the top byte, field ends nbytes later
    slot     = 5'd8 - {2'b00, off} - {1'b0, nbytes};
    lsb      = misalign ? 6'd0 : {slot[2:0], 3'b000};
    case (cmd.size)
      SZ_BYTE: mask = {{(WORD_W-8){1'b0}},  8'hFF};
      SZ_HALF: mask = {{(WORD_W-16){1'b0}}, 16'hFFFF};
      SZ_WORD: mask = {{(WORD_W-32){1'b0}}, 32'hFFFF_FFFF};
      default: mask = {WORD_W{1'b1}};
    endcase
    incr_ext = {{(WORD_W-INCR_W){cmd.incr[INCR_W-1]}}, cmd.incr};
    opnd     = (is_store ? wdata : incr_ext) & mask;
    noadd    = is_store & cmd.flag;
    tagwait  = ~is_store & cmd.flag;
  end

endmodule

// File: rtl/fetch_add_lane.sv
module fetch_add_lane
  import fetch_add_pkg::*;
(
  input  logic [WORD_W-1:0] old_word,
  input  logic [5:0]        lsb,
  input  logic [WORD_W-1:0] mask,
  input  logic [WORD_W-1:0] opnd,
  input  logic              noadd,
  output logic [WORD_W-1:0] old_field,
  output logic [WORD_W-1:0] new_word
);

  logic [WORD_W-1:0] new_field;
  logic [WORD_W-1:0] lane_mask;

  always_comb begin
    old_field = (old_word >> lsb) & mask;
    new_field = noadd ? opnd : ((old_field + opnd) & mask);
    lane_mask = mask << lsb;
    new_word  = (old_word & ~lane_mask) | (new_field << lsb);
  end

endmodule

// File: rtl/fetch_add_ctl.sv
module fetch_add_ctl
  import fetch_add_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic tagwait,
  input  logic misalign,
  input  logic tag_done,
  output logic ready,
  output logic in_hold,
  output logic hold_load,
  output logic wr_en,
  output logic rsp_fire,
  output logic rsp_err,
  output logic rsp_tw
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    wr_en     = 1'b0;
    rsp_fire  = 1'b0;
    rsp_err   = 1'b0;
    rsp_tw    = 1'b0;
    hold_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (misalign) begin
            rsp_fire = 1'b1;
            rsp_err  = 1'b1;
          end else if (tagwait) begin
            state_d   = ST_HOLD;
            cnt_d     = '0;
            hold_load = 1'b1;
          end else begin
            wr_en    = 1'b1;
            rsp_fire = 1'b1;
          end
        end
      end
      default: begin
        if (tag_done) begin
          wr_en    = 1'b1;
          rsp_fire = 1'b1;
          rsp_tw   = 1'b1;
          state_d  = ST_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          rsp_fire = 1'b1;
          rsp_err  = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ready   = (state_q == ST_IDLE);
  assign in_hold = (state_q == ST_HOLD);

  // R9: while held, the window counter advances by one per edge
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && $past(state_q == ST_HOLD)) |-> (cnt_q == $past(cnt_q) + 1'b1));

  // R9: a held load never stays held past the window
  a_r9_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> (cnt_q < CNT_W'(TIMEOUT_CYCLES)));

endmodule

// File: rtl/fetch_add_bank.sv
module fetch_add_bank
  import fetch_add_pkg::*;
#(
  parameter int BANK_BYTES     = 2048,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              tag_done,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [WORD_W-1:0] rsp_data
);

  localparam int NUM_WORDS = BANK_BYTES / 8;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  cmd_t              hold_cmd_q;
  cmd_t              sel_cmd;
  logic              sel_store;
  logic [IDX_W-1:0]  word_idx;
  logic [5:0]        lsb;
  logic [WORD_W-1:0] mask, opnd, old_word, old_field, new_word;
  logic              misalign, noadd, tagwait;
  logic              in_hold, hold_load, wr_en, fire, err_now, tw_now;
  logic [WORD_W-1:0] mem_q [NUM_WORDS];
  logic [WORD_W-1:0] rsp_data_d;

  assign sel_cmd   = in_hold ? hold_cmd_q : cmd_t'(req_cmd);
  assign sel_store = in_hold ? 1'b0 : req_store;

  fetch_add_decode #(.IDX_W(IDX_W)) u_dec (
    .cmd      (sel_cmd),
    .is_store (sel_store),
    .wdata    (req_wdata),
    .word_idx (word_idx),
    .lsb      (lsb),
    .mask     (mask),
    .opnd     (opnd),
    .misalign (misalign),
    .noadd    (noadd),
    .tagwait  (tagwait)
  );

  assign old_word = mem_q[word_idx];

  fetch_add_lane u_lane (
    .old_word  (old_word),
    .lsb       (lsb),
    .mask      (mask),
    .opnd      (opnd),
    .noadd     (noadd),
    .old_field (old_field),
    .new_word  (new_word)
  );

  fetch_add_ctl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .tagwait   (tagwait),
    .misalign  (misalign),
    .tag_done  (tag_done),
    .ready     (req_ready),
    .in_hold   (in_hold),
    .hold_load (hold_load),
    .wr_en     (wr_en),
    .rsp_fire  (fire),
    .rsp_err   (err_now),
    .rsp_tw    (tw_now)
  );

  always_comb begin
    if (err_now)     rsp_data_d = ERR_PATTERN;
    else if (tw_now) rsp_data_d = {1'b0, old_field[WORD_W-2:0]};
    else             rsp_data_d = old_field;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cmd_q <= '0;
    end else if (hold_load) begin
      hold_cmd_q <= cmd_t'(req_cmd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORDS; w++) mem_q[w] <= '0;
    end else if (wr_en) begin
      mem_q[word_idx] <= new_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fire;
      rsp_err   <= err_now;
      if (fire) rsp_data <= rsp_data_d;
    end
  end

  // R1: a request that is not held is answered at the next edge
  a_r1_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(!req_store && req_cmd[13])) |=> rsp_valid);

  // R7: a misaligned access never writes the bank
  a_r7_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !misalign);

  // R7: error responses carry only the flag bit
  a_r7_err_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == ERR_PATTERN));

  // R8: an accepted aligned held load drops ready at the next edge
  a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_store && req_cmd[13] && !misalign) |=> !req_ready);

  // R4: a write changes only the bytes of the addressed field
  a_r4_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (((new_word ^ old_word) & ~(mask << lsb)) == '0));

endmodule

// File: tb/fetch_add_bank_tb.sv
module fetch_add_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, tag_done;
  logic [35:0] req_cmd;
  logic [63:0] req_wdata;
  logic        req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_data;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] model [2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_add_bank #(.BANK_BYTES(2048), .TIMEOUT_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_cmd(req_cmd), .req_wdata(req_wdata),
    .tag_done(tag_done), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string rq, input string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  function automatic logic [63:0] rd_m(input int a, input int sz);
    logic [63:0] v = '0;
    for (int k = 0; k < (1 << sz); k++) v = (v << 8) | 64'(model[a+k]);
    return v;
  endfunction

  task automatic wr_m(input int a, input int sz, input logic [63:0] v);
    int n = 1 << sz;
    for (int k = 0; k < n; k++) model[a+k] = 8'(v >> (8*(n-1-k)));
  endtask

  function automatic logic [63:0] wmask(input int sz);
    return (sz == 3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  // drive one request, let it be accepted, capture the response
  task automatic issue(input bit st, input bit fl, input int sz, input int a,
                       input logic [21:0] inc, input logic [63:0] wd);
    req_valid = 1'b1;
    req_store = st;
    req_cmd   = {inc, fl, 2'(sz), 11'(a)};
    req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // non-held request checked against the byte model
  task automatic run_op(input bit st, input bit fl, input int sz, input int a,
                        input logic [21:0] inc, input logic [63:0] wd, input string rq);
    logic [63:0] m, old, op, nv;
    issue(st, fl, sz, a, inc, wd);
    chk(64'(rsp_valid), 64'd1, rq, "rsp_valid");
    if ((a % (1 << sz)) != 0) begin
      chk(64'(rsp_err), 64'd1, "R7", "misaligned err");
      chk(rsp_data, 64'h8000_0000_0000_0000, "R7", "misaligned data");
    end else begin
      m   = wmask(sz);
      old = rd_m(a, sz);
      op  = st ? (wd & m) : ({{42{inc[21]}}, inc} & m);
      nv  = (st && fl) ? op : ((old + op) & m);
      wr_m(a, sz, nv);
      chk(64'(rsp_err), 64'd0, rq, "err");
      chk(rsp_data, old, rq, "prior value");
    end
  endtask

  // held load: tag_done raised for the edge number dly (0 = never)
  task automatic held_op(input int sz, input int a, input logic [21:0] inc, input int dly, input string rq);
    logic [63:0] m, old, nv;
    int edges = 0;
    issue(1'b0, 1'b1, sz, a, inc, 64'd0);
    chk(64'(rsp_valid), 64'd0, "R8", "no rsp at accept");
    chk(64'(req_ready), 64'd0, "R8", "ready low while held");
    for (int i = 1; i <= TMO + 2; i++) begin
      tag_done = (i == dly);
      @(posedge clk); #1;
      edges = i;
      if (rsp_valid) break;
    end
    tag_done = 1'b0;
    m   = wmask(sz);
    old = rd_m(a, sz);
    if (dly >= 1 && dly <= TMO) begin
      nv = (old + ({{42{inc[21]}}, inc} & m)) & m;
      wr_m(a, sz, nv);
      chk(64'(edges), 64'(dly), rq, "release edge");
      chk(64'(rsp_err), 64'd0, rq, "held err");
      chk(rsp_data, {1'b0, old[62:0]}, rq, "held data");
    end else begin
      chk(64'(edges), 64'(TMO), "R9", "timeout edge");
      chk(64'(rsp_err), 64'd1, "R9", "timeout err");
      chk(rsp_data, 64'h8000_0000_0000_0000, "R9", "timeout data");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2048; b++) model[b] = 8'd0;
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_cmd = '0;
    req_wdata = '0; tag_done = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R11: reset state
    chk(64'(rsp_valid), 64'd0, "R11", "rsp_valid after reset");
    chk(64'(req_ready), 64'd1, "R11", "ready after reset");
    run_op(1'b0, 1'b0, 3, 2040, 22'd0, 64'd0, "R11");
    chk(rsp_data, 64'd0, "R11", "counter zero after reset");

    // R1 R2 R3 R7: every size at every byte offset, two increments each
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 8; o++) begin
        run_op(1'b0, 1'b0, sz, 40 + o, 22'(o * 37 + sz * 5 + 1), 64'd0, "R1");
        run_op(1'b0, 1'b0, sz, 40 + o, 22'h3FFFF0 - 22'(o), 64'd0, "R3");
      end
    for (int o = 0; o < 8; o++) run_op(1'b0, 1'b0, 0, 40 + o, 22'd0, 64'd0, "R4");

    // R6: store add and overwrite sweep
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 8; o += (1 << sz)) begin
        run_op(1'b1, 1'b1, sz, 72 + o, 22'd0, 64'hA5C3_1F2E_8D7B_6049 + 64'(o), "R6");
        run_op(1'b1, 1'b0, sz, 72 + o, 22'd0, 64'hF0E1_D2C3_B4A5_9687, "R6");
      end
    run_op(1'b1, 1'b0, 2, 74, 22'd0, 64'd5, "R7");

    // R5: big-endian byte order
    run_op(1'b1, 1'b1, 3, 80, 22'd0, 64'h0102_0304_0506_0708, "R5");
    for (int k = 0; k < 8; k++) begin
      run_op(1'b0, 1'b0, 0, 80 + k, 22'd0, 64'd0, "R5");
      chk(rsp_data, 64'(k + 1), "R5", "byte at offset");
    end
    run_op(1'b0, 1'b0, 1, 82, 22'd0, 64'd0, "R5");
    chk(rsp_data, 64'h0304, "R5", "half at offset 2");

    // R4: byte wrap leaves neighbours alone
    run_op(1'b1, 1'b1, 0, 88, 22'd0, 64'hFF, "R4");
    run_op(1'b0, 1'b0, 0, 88, 22'd1, 64'd0, "R4");
    chk(rsp_data, 64'hFF, "R4", "wrap prior");
    run_op(1'b0, 1'b0, 3, 88, 22'd0, 64'd0, "R4");
    chk(rsp_data, 64'd0, "R4", "word after byte wrap");

    // R3: -1 into 32- and 64-bit zero fields
    run_op(1'b0, 1'b0, 2, 96, 22'h3FFFFF, 64'd0, "R3");
    run_op(1'b0, 1'b0, 2, 96, 22'd0, 64'd0, "R3");
    chk(rsp_data, 64'hFFFF_FFFF, "R3", "32-bit all ones");
    run_op(1'b0, 1'b0, 3, 104, 22'h3FFFFF, 64'd0, "R3");
    run_op(1'b0, 1'b0, 3, 104, 22'd0, 64'd0, "R3");
    chk(rsp_data, 64'hFFFF_FFFF_FFFF_FFFF, "R3", "64-bit all ones");

    // R10: back-to-back to the same field, no idle cycles
    for (int i = 0; i < 12; i++)
      run_op(i[0], 1'b0, 1, 112, 22'(i * 3 + 1), 64'(i * 7 + 2), "R10");
    run_op(1'b0, 1'b0, 1, 112, 22'd0, 64'd0, "R10");
    chk(rsp_data, rd_m(112, 1), "R10", "final sum");

    // R8 R9: held loads at every release delay, timeout, last-cycle race
    for (int d = 1; d <= TMO; d++) held_op(d % 4, 128 + 8 * d, 22'(d + 2), d, "R8");
    held_op(3, 200, 22'd9, TMO, "R9");
    held_op(2, 208, 22'd9, 0, "R9");
    run_op(1'b0, 1'b0, 2, 208, 22'd0, 64'd0, "R9");
    chk(rsp_data, 64'd0, "R9", "no update after timeout");
    run_op(1'b1, 1'b1, 3, 216, 22'd0, 64'hC000_0000_0000_0011, "R8");
    held_op(3, 216, 22'd1, 2, "R8");
    issue(1'b0, 1'b1, 2, 226, 22'd1, 64'd0);
    chk(64'(rsp_err), 64'd1, "R7", "held misaligned err");
    chk(64'(req_ready), 64'd1, "R7", "held misaligned not held");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule